// File: doc/BRIEF.md
# Configurable General-Purpose I/O Port

This block is one port of general-purpose pins, eight by default. Software sets each pin through three registers: a data latch, a direction mask and an option mask. Bit n of each register belongs to pin n. From these bits and from the pin's own level, the block computes four things for each pad: the drive value, the output enable, the pull-up enable, and a flag marking the pin as an interrupt source. The interrupt detector downstream uses that flag.

The option bit means different things in the two directions. On an input it turns on both the pull-up and interrupt generation. On an output it picks open-drain instead of push-pull. An on-chip peripheral can take over a pin through its own output and enable signals. While it holds the pin, the pin is driven from the peripheral's value whatever the registers say.

The pad level passes through a two-stage synchronizer. The synchronized level goes to peripherals that use the pin as an input, and software reads it back through the data register.

Top module: `gpio_port`

## Requirements
- R1: Register select 0 addresses the data latch, 1 the direction mask and 2 the option mask. A write takes effect at the clock edge on which `reg_we` is high. Select 3 reads back zero, and writes to it change nothing.
- R2: After reset all three registers hold zero. Every pad then has output enable 0, pull-up 0 and interrupt flag 0, and every pin is a floating input.
- R3: With direction bit 0, data readback and `alt_in` show the pad level two clock edges after it changes at `pad_in`.
- R4: On an input pin (direction 0) with no peripheral drive, `pad_pu` and `irq_en` both equal the option bit, and the output enable is 0.
- R5: On an output pin (direction 1) with option 0, the pad is push-pull: output enable 1 and drive value equal to the latch bit. Pull-up and interrupt flag are 0.
- R6: On an output pin with option 1, the pad is open-drain. A latch bit of 0 gives output enable 1 with drive value 0. A latch bit of 1 gives output enable 0.
- R7: With direction bit 1, data readback returns the latch bit and ignores the pad level.
- R8: While `alt_oe[n]` is 1, pad n has output enable 1 and drive value `alt_out[n]`, with pull-up and interrupt flag 0, for every setting of the direction and option bits.
- R9: A latch value written while the pin is an input appears on the pad at the same clock edge at which the direction bit becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 data, 1 direction, 2 option |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| pad_in | input | 8 | Level seen at the pads |
| pad_out | output | 8 | Pad drive value |
| pad_oe | output | 8 | Pad output enable |
| pad_pu | output | 8 | Pad pull-up enable |
| alt_out | input | 8 | Peripheral output value for each pin |
| alt_oe | input | 8 | Peripheral takes over the pin |
| alt_in | output | 8 | Synchronized pad level for peripherals |
| irq_en | output | 8 | Pin is an interrupt source |

## Verification
The override by a peripheral and a register write can fall in the same cycle. The bench provokes this by raising `alt_oe` on every pin in the same clock as a write that turns all pins into push-pull outputs, and another write that loads a different latch pattern. It judges the result in two steps. While the override is held, the pads must show only the peripheral's value. Once the override is released, they must show the new latch pattern with no further write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_OPT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic drv;
    logic oe;
    logic pu;
    logic irq;
  } pin_ctl_t;

  // Per-pin pad control from register bits and peripheral override.
  function automatic pin_ctl_t pin_control(input logic dir, input logic opt,
                                           input logic lat, input logic a_oe,
                                           input logic a_out);
    pin_ctl_t c;
    c = '0;
    if (a_oe) begin
      c.drv = a_out;
      c.oe  = 1'b1;
    end else if (dir) begin
      if (opt) begin
        c.drv = 1'b0;
        c.oe  = ~lat;
      end else begin
        c.drv = lat;
        c.oe  = 1'b1;
      end
    end else begin
      c.pu  = opt;
      c.irq = opt;
    end
    return c;
  endfunction

  // Data readback: latch on outputs, synchronized level on inputs.
  function automatic logic data_view(input logic dir, input logic lat,
                                     input logic lvl);
    return dir ? lat : lvl;
  endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [SEL_W-1:0]     sel,
  input  logic [W-1:0]         wdata,
  output logic [W-1:0]         lat_q,
  output logic [W-1:0]         dir_q,
  output logic [W-1:0]         opt_q
);

  logic wr_lat, wr_dir, wr_opt;

  always_comb begin
    wr_lat = we && (reg_sel_e'(sel) == SEL_DATA);
    wr_dir = we && (reg_sel_e'(sel) == SEL_DIR);
    wr_opt = we && (reg_sel_e'(sel) == SEL_OPT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '0;
      opt_q <= '0;
    end else begin
      if (wr_lat) lat_q <= wdata;
      if (wr_dir) dir_q <= wdata;
      if (wr_opt) opt_q <= wdata;
    end
  end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
  import gpio_pkg::*;
(
  input  logic dir,
  input  logic opt,
  input  logic lat,
  input  logic lvl,
  input  logic a_oe,
  input  logic a_out,
  output logic drv,
  output logic oe,
  output logic pu,
  output logic irq,
  output logic rd
);

  pin_ctl_t ctl;

  always_comb begin
    ctl = pin_control(dir, opt, lat, a_oe, a_out);
    drv = ctl.drv;
    oe  = ctl.oe;
    pu  = ctl.pu;
    irq = ctl.irq;
    rd  = data_view(dir, lat, lvl);
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  input  logic [W-1:0]     pad_in,
  output logic [W-1:0]     pad_out,
  output logic [W-1:0]     pad_oe,
  output logic [W-1:0]     pad_pu,
  input  logic [W-1:0]     alt_out,
  input  logic [W-1:0]     alt_oe,
  output logic [W-1:0]     alt_in,
  output logic [W-1:0]     irq_en
);

  logic [W-1:0] lat_q, dir_q, opt_q;
  logic [W-1:0] pin_sync;
  logic [W-1:0] data_rd;

  gpio_regs #(.W(W)) regs_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .lat_q (lat_q),
    .dir_q (dir_q),
    .opt_q (opt_q)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  for (genvar n = 0; n < W; n++) begin : g_pin
    gpio_pin pin_i (
      .dir   (dir_q[n]),
      .opt   (opt_q[n]),
      .lat   (lat_q[n]),
      .lvl   (pin_sync[n]),
      .a_oe  (alt_oe[n]),
      .a_out (alt_out[n]),
      .drv   (pad_out[n]),
      .oe    (pad_oe[n]),
      .pu    (pad_pu[n]),
      .irq   (irq_en[n]),
      .rd    (data_rd[n])
    );
  end

  assign alt_in = pin_sync;

  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_DATA: reg_rdata = data_rd;
      SEL_DIR:  reg_rdata = dir_q;
      SEL_OPT:  reg_rdata = opt_q;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [SEL_W-1:0] reg_sel,
  input logic [W-1:0]     reg_wdata,
  input logic [W-1:0]     pad_in,
  input logic [W-1:0]     pad_out,
  input logic [W-1:0]     pad_oe,
  input logic [W-1:0]     pad_pu,
  input logic [W-1:0]     alt_out,
  input logic [W-1:0]     alt_oe,
  input logic [W-1:0]     alt_in,
  input logic [W-1:0]     irq_en,
  input logic [W-1:0]     dir_q,
  input logic [W-1:0]     opt_q,
  input logic [W-1:0]     lat_q
);

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_DIR) |=> (dir_q == $past(reg_wdata))); // R1

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_pu == '0 && irq_en == '0 && dir_q == '0)); // R2

  for (genvar n = 0; n < W; n++) begin : g_chk
    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alt_in[n]) |-> $past(pad_in[n], 2)); // R3

    AST_IRQ_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en[n] |-> (!pad_oe[n] && !dir_q[n] && !alt_oe[n])); // R4

    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_q[n] && opt_q[n] && !alt_oe[n]) |-> !(pad_oe[n] && pad_out[n])); // R6

    AST_ALT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      alt_oe[n] |-> (pad_oe[n] && pad_out[n] == alt_out[n] && !pad_pu[n])); // R8
  end

endmodule

bind gpio_port gpio_port_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pad_pu    (pad_pu),
  .alt_out   (alt_out),
  .alt_oe    (alt_oe),
  .alt_in    (alt_in),
  .irq_en    (irq_en),
  .dir_q     (dir_q),
  .opt_q     (opt_q),
  .lat_q     (lat_q)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe, pad_pu, alt_in, irq_en;
  logic [7:0] alt_out = 8'h00;
  logic [7:0] alt_oe = 8'h00;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_port dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in), .irq_en(irq_en)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    reg_sel = sel; reg_wdata = val; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] val);
    reg_sel = sel;
    #1;
    val = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R2", "oe after reset", pad_oe, 8'h00);
    check("R2", "pu after reset", pad_pu, 8'h00);
    check("R2", "irq after reset", irq_en, 8'h00);
    rd(2'd1, v); check("R2", "dir after reset", v, 8'h00);
    rd(2'd2, v); check("R2", "opt after reset", v, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(2'd2, 8'h5A);
    rd(2'd2, v); check("R1", "opt readback", v, 8'h5A);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); check("R1", "reserved reads zero", v, 8'h00);
    rd(2'd2, v); check("R1", "reserved write leaves opt", v, 8'h5A);
    rd(2'd1, v); check("R1", "reserved write leaves dir", v, 8'h00);
    check("R1", "reserved write leaves pads", pad_oe, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_input;
    logic [7:0] v;
    @(negedge clk); pad_in = 8'hC3;
    @(negedge clk); #1;
    rd(2'd0, v); check("R3", "one edge after pad change", v, 8'h00);
    @(negedge clk); #1;
    rd(2'd0, v); check("R3", "two edges after pad change", v, 8'hC3);
    check("R3", "alt_in level", alt_in, 8'hC3);
    wr(2'd2, 8'h0F);
    check("R4", "pull-up follows option", pad_pu, 8'h0F);
    check("R4", "irq follows option", irq_en, 8'h0F);
    check("R4", "inputs not driven", pad_oe, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_preload_output;
    logic [7:0] v;
    wr(2'd0, 8'h96);
    check("R9", "input pins stay undriven", pad_oe, 8'h00);
    wr(2'd1, 8'hFF);
    check("R9", "preloaded latch on pads", pad_out, 8'h96);
    check("R5", "push-pull enables", pad_oe, 8'hFF);
    check("R5", "no pull-up on outputs", pad_pu, 8'h00);
    rd(2'd0, v); check("R7", "readback is latch", v, 8'h96);
    wr(2'd2, 8'hFF);
    check("R5", "no irq on outputs", irq_en, 8'h00);
    check("R6", "open-drain enables", pad_oe, 8'h69);
    check("R6", "open-drain never drives high", pad_out & pad_oe, 8'h00);
    @(negedge clk); pad_in = 8'h00;
    repeat (2) @(negedge clk); #1;
    rd(2'd0, v); check("R7", "readback ignores pad", v, 8'h96);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_alt_collision;
    logic [7:0] v;
    @(negedge clk);
    alt_out = 8'hA5; alt_oe = 8'hFF;
    reg_sel = 2'd1; reg_wdata = 8'hFF; reg_we = 1'b1;
    @(negedge clk);
    reg_sel = 2'd0; reg_wdata = 8'h3C;
    @(negedge clk);
    reg_we = 1'b0; #1;
    check("R8", "alt value wins over write", pad_out, 8'hA5);
    check("R8", "alt enables all", pad_oe, 8'hFF);
    rd(2'd0, v); check("R1", "latch took write under alt", v, 8'h3C);
    @(negedge clk); alt_oe = 8'h00; #1;
    check("R5", "latch after alt release", pad_out, 8'h3C);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hFF);
    @(negedge clk); alt_oe = 8'h0F; alt_out = 8'h00; #1;
    check("R8", "alt on input pins drives", pad_oe, 8'h0F);
    check("R8", "alt clears pull-up", pad_pu, 8'hF0);
    check("R8", "alt clears irq", irq_en, 8'hF0);
    @(negedge clk); alt_oe = 8'h00;
    wr(2'd2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_regs();
    t_input();
    t_preload_output();
    t_alt_collision();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule